// File: doc/BRIEF.md
# Watchdog Timer with Safe Frequency-Code Fallback

This block guards the frequency setting of a clock-generator control core. Once armed, it counts a programmable timeout made of a 3-bit multiplier times a base period. The base period is either short or four times longer, chosen by one bit. Both periods are counted in slow input ticks: the short base is `SHORT_TICKS` ticks and the long base is `SHORT_TICKS*LONG_FACTOR` ticks. Any completed write on the serial register interface services the watchdog and restarts the full timeout.

If the timeout runs out without service, the block raises an alarm. While the alarm is up, the effective 5-bit frequency-select code is replaced by a programmed safe code. In the cycle the alarm begins, a one-cycle system reset request is pulsed. The alarm status stays set until software clears the enable bit. The block returns to passing the requested code through in the cycle after the clear.

The control state machine has four states:
- `WD_IDLE`: disabled.
- `WD_ARMED`: counting.
- `WD_FIRE`: the single alarm-entry cycle.
- `WD_HOLD`: alarm held.

Its transitions are:
- IDLE→ARMED when the enable is seen set. The counter and prescaler reload.
- ARMED→ARMED on a service strobe. The counter and prescaler reload.
- ARMED→FIRE when the last base period of the timeout ends.
- FIRE→HOLD unconditionally while enabled.
- ARMED/FIRE/HOLD→IDLE whenever the enable is clear.

Top module: `wd_safefreq_top`

## Requirements
- R1: After reset `alarm_o` and `sys_rst_o` are 0 and `fs_eff_o` equals `fs_req_i`.
- R2: While `wd_en_i` is 0 no alarm and no reset request is ever raised, however many ticks arrive.
- R3: With `long_base_i`=0 and multiplier M≥1, `alarm_o` rises exactly 29·M clock cycles after the rising clock edge that first samples `wd_en_i`=1, given one tick per cycle.
- R4: With `long_base_i`=1 the timeout is 116·M cycles under the same conditions.
- R5: A multiplier of 0 expires at the first base-period boundary, i.e. after one base period.
- R6: A `wr_done_i` strobe while armed restarts the full timeout from the edge that samples it. A strobe in the same cycle as expiry wins, and no alarm is raised.
- R7: In the cycle the alarm rises, `sys_rst_o` is 1 for exactly one cycle and `fs_eff_o` equals `safe_fs_i`.
- R8: The alarm stays set, with `fs_eff_o`=`safe_fs_i`, despite service strobes or changes of `fs_req_i`, until `wd_en_i` is sampled 0. One cycle later `alarm_o` is 0 and `fs_eff_o` follows `fs_req_i`.
- R9: An enable transition from 0 to 1 reloads the timeout, so re-arming after an alarm yields a full fresh timeout.
- R10: Clearing `wd_en_i` in the cycle that would expire wins, and no alarm or reset request follows.
- R11: Only cycles with `tick_i`=1 advance the timeout; cycles with `tick_i`=0 pause it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Slow time tick, one cycle wide |
| wd_en_i | input | 1 | Watchdog arm bit |
| long_base_i | input | 1 | 0 = short base period, 1 = long base period |
| mult_i | input | 3 | Timeout multiplier in base periods |
| safe_fs_i | input | 5 | Safe frequency-select code used during alarm |
| wr_done_i | input | 1 | Completed serial-register write strobe (service) |
| fs_req_i | input | 5 | Frequency-select code requested by configuration |
| fs_eff_o | output | 5 | Frequency-select code in effect |
| alarm_o | output | 1 | Alarm status, 1 once the watchdog has expired |
| sys_rst_o | output | 1 | One-cycle system reset request |

## Verification
Two collisions are provoked, each in the very cycle whose edge would complete the final base period. In the first, the service strobe is driven so that it is sampled at that edge, and the bench expects the timeout to restart with no alarm and no reset pulse. In the second, the enable is cleared at that same edge, and the bench expects the block to fall back to idle with the alarm and reset request both absent. In both cases, the cycles that follow are watched for a late alarm, and the restarted timeout is timed to the exact cycle.

// File: rtl/wd_pkg.sv
package wd_pkg;

    typedef enum logic [1:0] {
        WD_IDLE  = 2'd0,
        WD_ARMED = 2'd1,
        WD_FIRE  = 2'd2,
        WD_HOLD  = 2'd3
    } wd_state_t;

endpackage

// File: rtl/wd_base_prescaler.sv
// Divides input ticks into base-period boundaries; short or long period.
module wd_base_prescaler #(
    parameter int SHORT_TICKS = 29,
    parameter int LONG_FACTOR = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic tick_i,
    input  logic long_i,
    output logic base_tick_o
);
    localparam int LONG_TICKS = SHORT_TICKS * LONG_FACTOR;
    localparam int CW         = $clog2(LONG_TICKS + 1);
    localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_TICKS - 1);
    localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_TICKS - 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last_val;

    always_comb begin
        last_val    = long_i ? LONG_LAST : SHORT_LAST;
        base_tick_o = tick_i && !clear_i && (cnt_q >= last_val);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear_i) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= base_tick_o ? '0 : cnt_q + CW'(1);
        end
    end
endmodule

// File: rtl/wd_period_counter.sv
// Counts remaining base periods of the current timeout.
module wd_period_counter #(
    parameter int MULT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              dec_i,
    input  logic [MULT_W-1:0] mult_i,
    output logic              last_o
);
    logic [MULT_W-1:0] left_q;

    // zero and one both mean: the next boundary ends the timeout
    assign last_o = (left_q <= MULT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q <= MULT_W'(7);
        end else if (load_i) begin
            left_q <= mult_i;
        end else if (dec_i) begin
            left_q <= left_q - MULT_W'(1);
        end
    end
endmodule

// File: rtl/wd_ctrl_fsm.sv
module wd_ctrl_fsm
    import wd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic service_i,
    input  logic base_tick_i,
    input  logic last_i,
    output logic load_o,
    output logic dec_o,
    output logic presc_clear_o,
    output logic alarm_o,
    output logic rst_pulse_o
);
    wd_state_t state_q;
    wd_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_IDLE:  if (en_i) state_d = WD_ARMED;
            WD_ARMED: begin
                if (!en_i)                            state_d = WD_IDLE;
                else if (service_i)                   state_d = WD_ARMED;
                else if (base_tick_i && last_i)       state_d = WD_FIRE;
            end
            WD_FIRE:  state_d = en_i ? WD_HOLD : WD_IDLE;
            WD_HOLD:  if (!en_i) state_d = WD_IDLE;
            default:  state_d = WD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WD_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        load_o        = 1'b0;
        dec_o         = 1'b0;
        presc_clear_o = 1'b1;
        alarm_o       = 1'b0;
        rst_pulse_o   = 1'b0;
        unique case (state_q)
            WD_IDLE:  load_o = en_i;
            WD_ARMED: begin
                load_o        = en_i && service_i;
                dec_o         = en_i && !service_i && base_tick_i && !last_i;
                presc_clear_o = !en_i || service_i;
            end
            WD_FIRE: begin
                alarm_o     = 1'b1;
                rst_pulse_o = 1'b1;
            end
            WD_HOLD:  alarm_o = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/wd_safefreq_top.sv
module wd_safefreq_top #(
    parameter int SHORT_TICKS = 29,
    parameter int LONG_FACTOR = 4,
    parameter int MULT_W      = 3,
    parameter int FS_W        = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              wd_en_i,
    input  logic              long_base_i,
    input  logic [MULT_W-1:0] mult_i,
    input  logic [FS_W-1:0]   safe_fs_i,
    input  logic              wr_done_i,
    input  logic [FS_W-1:0]   fs_req_i,
    output logic [FS_W-1:0]   fs_eff_o,
    output logic              alarm_o,
    output logic              sys_rst_o
);
    logic base_tick;
    logic presc_clear;
    logic last_period;
    logic load_cnt;
    logic dec_cnt;

    wd_base_prescaler #(
        .SHORT_TICKS(SHORT_TICKS),
        .LONG_FACTOR(LONG_FACTOR)
    ) u_presc (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (presc_clear),
        .tick_i     (tick_i),
        .long_i     (long_base_i),
        .base_tick_o(base_tick)
    );

    wd_period_counter #(.MULT_W(MULT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load_cnt),
        .dec_i  (dec_cnt),
        .mult_i (mult_i),
        .last_o (last_period)
    );

    wd_ctrl_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_i         (wd_en_i),
        .service_i    (wr_done_i),
        .base_tick_i  (base_tick),
        .last_i       (last_period),
        .load_o       (load_cnt),
        .dec_o        (dec_cnt),
        .presc_clear_o(presc_clear),
        .alarm_o      (alarm_o),
        .rst_pulse_o  (sys_rst_o)
    );

    for (genvar b = 0; b < FS_W; b++) begin : g_fs_sel
        assign fs_eff_o[b] = alarm_o ? safe_fs_i[b] : fs_req_i[b];
    end
endmodule

// File: rtl/wd_safefreq_chk.sv
module wd_safefreq_chk (
    input logic clk,
    input logic rst_n,
    input logic wd_en_i,
    input logic alarm_o,
    input logic sys_rst_o
);
    p_rst_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_o |=> !sys_rst_o);

    p_rst_with_alarm_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_o |-> alarm_o);

    p_alarm_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_o) |-> sys_rst_o);

    p_alarm_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_o && wd_en_i) |=> alarm_o);

    p_disable_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wd_en_i |=> (!alarm_o && !sys_rst_o));
endmodule

bind wd_safefreq_top wd_safefreq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wd_en_i  (wd_en_i),
    .alarm_o  (alarm_o),
    .sys_rst_o(sys_rst_o)
);

// File: tb/wd_safefreq_top_tb.sv
module wd_safefreq_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int T_SHORT    = 29;
    localparam int T_LONG     = 116;
    localparam int NVEC       = 6;
    // {long_base, mult[2:0], safe_fs[4:0], fs_req[4:0]}
    localparam logic [13:0] VEC [NVEC] = '{
        {1'b0, 3'd7, 5'h04, 5'h11},
        {1'b0, 3'd1, 5'h1f, 5'h00},
        {1'b1, 3'd2, 5'h0a, 5'h15},
        {1'b0, 3'd0, 5'h03, 5'h1c},
        {1'b1, 3'd0, 5'h12, 5'h07},
        {1'b0, 3'd3, 5'h00, 5'h1e}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b1;
    logic       wd_en_i = 1'b0;
    logic       long_base_i = 1'b0;
    logic [2:0] mult_i = 3'd7;
    logic [4:0] safe_fs_i = 5'h00;
    logic       wr_done_i = 1'b0;
    logic [4:0] fs_req_i = 5'h09;
    logic [4:0] fs_eff_o;
    logic       alarm_o;
    logic       sys_rst_o;

    int checks = 0;
    int failures = 0;
    int rst_seen = 0;
    int cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wd_safefreq_top u_dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wd_en_i(wd_en_i),
        .long_base_i(long_base_i), .mult_i(mult_i), .safe_fs_i(safe_fs_i),
        .wr_done_i(wr_done_i), .fs_req_i(fs_req_i), .fs_eff_o(fs_eff_o),
        .alarm_o(alarm_o), .sys_rst_o(sys_rst_o)
    );

    always @(negedge clk) if (sys_rst_o) rst_seen++;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic adv(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int tmo(input logic [2:0] m, input logic lng);
        return ((m == 3'd0) ? 1 : int'(m)) * (lng ? T_LONG : T_SHORT);
    endfunction

    // arm from disabled; caller is at a negedge with wd_en_i = 0
    task automatic arm();
        wd_en_i = 1'b1;
        adv(1);                     // edge k has sampled enable
    endtask

    task automatic disarm();
        wd_en_i = 1'b0;
        adv(1);
    endtask

    initial begin
        int n;
        int base_rst;
        adv(3);
        rst_n = 1'b1;
        adv(1);
        // R1 reset state
        chk(alarm_o == 1'b0, "R1", "alarm", alarm_o, 0);
        chk(sys_rst_o == 1'b0, "R1", "sys_rst", sys_rst_o, 0);
        chk(fs_eff_o == fs_req_i, "R1", "fs_eff", fs_eff_o, fs_req_i);

        // R2 disabled: no alarm over many ticks
        mult_i = 3'd1;
        base_rst = rst_seen;
        adv(300);
        chk(alarm_o == 1'b0, "R2", "alarm while disabled", alarm_o, 0);
        chk(rst_seen == base_rst, "R2", "reset pulses", rst_seen - base_rst, 0);

        // R3 R4 R5 R7 R9: table of timeouts, each re-armed from disabled
        for (int i = 0; i < NVEC; i++) begin
            long_base_i = VEC[i][13];
            mult_i      = VEC[i][12:10];
            safe_fs_i   = VEC[i][9:5];
            fs_req_i    = VEC[i][4:0];
            n = tmo(mult_i, long_base_i);
            arm();
            adv(n - 1);
            chk(alarm_o == 1'b0, "R3/R4/R5 R9", "alarm one cycle early", alarm_o, 0);
            chk(fs_eff_o == fs_req_i, "R9", "fs before expiry", fs_eff_o, fs_req_i);
            adv(1);
            chk(alarm_o == 1'b1, long_base_i ? "R4" : (mult_i == 0 ? "R5" : "R3"),
                "alarm at timeout", alarm_o, 1);
            chk(sys_rst_o == 1'b1, "R7", "reset pulse", sys_rst_o, 1);
            chk(fs_eff_o == safe_fs_i, "R7", "safe code", fs_eff_o, safe_fs_i);
            adv(1);
            chk(sys_rst_o == 1'b0, "R7", "pulse width", sys_rst_o, 0);
            disarm();
        end

        // R8 alarm held despite service and fs_req changes
        long_base_i = 1'b0; mult_i = 3'd1; safe_fs_i = 5'h0b; fs_req_i = 5'h14;
        arm();
        adv(T_SHORT);
        chk(alarm_o == 1'b1, "R8", "alarm raised", alarm_o, 1);
        wr_done_i = 1'b1; fs_req_i = 5'h02;
        adv(1);
        wr_done_i = 1'b0;
        adv(20);
        chk(alarm_o == 1'b1, "R8", "alarm held after service", alarm_o, 1);
        chk(fs_eff_o == 5'h0b, "R8", "safe code held", fs_eff_o, 5'h0b);
        disarm();
        chk(alarm_o == 1'b0, "R8", "alarm cleared", alarm_o, 0);
        chk(fs_eff_o == 5'h02, "R8", "passthrough restored", fs_eff_o, 5'h02);

        // R6 service mid-count restarts full timeout
        mult_i = 3'd2;
        arm();                       // at k
        adv(39);                     // at k+39, drive strobe for edge k+40
        wr_done_i = 1'b1;
        adv(1);
        wr_done_i = 1'b0;
        adv(2 * T_SHORT - 1);
        chk(alarm_o == 1'b0, "R6", "no alarm before restarted timeout", alarm_o, 0);
        adv(1);
        chk(alarm_o == 1'b1, "R6", "alarm at restarted timeout", alarm_o, 1);
        disarm();

        // R6 service in the expiry cycle wins
        mult_i = 3'd1;
        base_rst = rst_seen;
        arm();
        adv(T_SHORT - 1);
        wr_done_i = 1'b1;
        adv(1);                      // edge k+29 samples service
        wr_done_i = 1'b0;
        chk(alarm_o == 1'b0, "R6", "collision: service beats expiry", alarm_o, 0);
        adv(T_SHORT - 1);
        chk(alarm_o == 1'b0, "R6", "no alarm before new timeout", alarm_o, 0);
        chk(rst_seen == base_rst, "R6", "no reset pulse", rst_seen - base_rst, 0);
        adv(1);
        chk(alarm_o == 1'b1, "R6", "alarm after new timeout", alarm_o, 1);
        disarm();

        // R10 disable in the expiry cycle wins
        base_rst = rst_seen;
        arm();
        adv(T_SHORT - 1);
        wd_en_i = 1'b0;
        adv(1);
        chk(alarm_o == 1'b0, "R10", "collision: disable beats expiry", alarm_o, 0);
        adv(40);
        chk(alarm_o == 1'b0, "R10", "no late alarm", alarm_o, 0);
        chk(rst_seen == base_rst, "R10", "no reset pulse", rst_seen - base_rst, 0);

        // R11 ticks low pause the timeout
        tick_i = 1'b0;
        arm();
        adv(100);
        chk(alarm_o == 1'b0, "R11", "paused without ticks", alarm_o, 0);
        tick_i = 1'b1;
        adv(T_SHORT - 1);
        chk(alarm_o == 1'b0, "R11", "alarm early after resume", alarm_o, 0);
        adv(1);
        chk(alarm_o == 1'b1, "R11", "alarm after counted ticks", alarm_o, 1);
        disarm();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                failures++;
                $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end
endmodule